// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Selector

This block picks which pending DRAM request a memory controller should serve next. It looks at a queue of requests, each tagged with a rank, a bank and a row. Alongside the queue it sees the live status of every bank: whether a row is open and which one, the earliest cycle a precharge may be issued, and the earliest cycle an activate may be issued. Entry 0 of the queue is the oldest and the highest index is the youngest.

Each clock edge captures a snapshot of all inputs. The selection is pure combinational logic over that snapshot, so a result appears one cycle after its inputs. Row hits win first, and among hits the oldest one is taken. With no hit, the block estimates for each bank when an activate could go out. A closed bank uses its activate-allowed time. An open bank uses the later of its precharge-allowed time and the current cycle, plus the precharge period. The block then marks every bank that has waiting work and the smallest estimate, ties included. It picks the oldest request whose bank is ready now or is marked. The mask is also an output, so downstream logic can see which banks were judged earliest.

Queue storage, command issue and updates to bank timing belong to other blocks.

Top module: `rowhit_selector`

## Requirements
- R1: Outputs depend only on inputs captured at the previous rising clock edge. While reset is asserted, and on the first cycle after it, pick_valid_o is 0 and early_mask_o is 0.
- R2: With no valid queue entry, pick_valid_o is 0 and early_mask_o is 0.
- R3: If any valid entry targets an open bank whose open row equals the entry's row, pick_valid_o is 1, pick_idx_o is the lowest such index (the oldest), and early_mask_o is 0.
- R4: For a bank with no open row (bk_open_i bit 0), the activate estimate is its activate-allowed time.
- R5: For a bank with an open row, the activate estimate is max(precharge-allowed time, now_i) + t_rp_i.
- R6: A bank can have a mask bit only if at least one valid entry targets it.
- R7: With no row hit, early_mask_o has a bit set for every waiting bank whose estimate equals the minimum over waiting banks, so ties leave several bits set.
- R8: A bank's flat index, used for mask bit positions and for the per-bank input slices, is rank * BANKS_PER_RANK + bank, with at most 64 banks.
- R9: With no row hit and a non-empty queue, pick_idx_o is the lowest valid index whose bank estimate is <= now_i or whose bank bit is set in the mask.
- R10: Entries whose valid bit is 0 are never selected, never count as hits and never make a bank waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the snapshot |
| now_i | input | 32 | Current cycle count |
| t_rp_i | input | 32 | Precharge period in cycles |
| q_valid_i | input | 16 | Entry valid bits, index 0 oldest |
| q_rank_i | input | 16*1 | Rank per entry, entry e at [e*1 +: 1] |
| q_bank_i | input | 16*3 | Bank within rank per entry |
| q_row_i | input | 16*14 | Row per entry |
| bk_open_i | input | 16 | Row-open flag per flat bank |
| bk_row_i | input | 16*14 | Open row per flat bank |
| bk_pre_at_i | input | 16*32 | Earliest precharge cycle per flat bank |
| bk_act_at_i | input | 16*32 | Earliest activate cycle per flat bank |
| pick_valid_o | output | 1 | A request is selected |
| pick_idx_o | output | 4 | Index of the selected entry |
| early_mask_o | output | 16 | Banks with the earliest activate estimate, zero on a row hit |

## Verification
A wrong snapshot would show as outputs that follow inputs a cycle early or late, seen at the first sample after a change. A wrong estimate or a wrong minimum shows up in the same cycle: the mask gets a missing or extra bit, and often the picked index changes as well. Errors in the priority scans show as a younger entry picked over an older one. The directed cases force ties, ready-but-not-minimum banks, invalid entries that would hit, and the last queue slot. Hundreds of pseudo-random snapshots with small values, which make ties common, are then compared against an arithmetic model.

// File: rtl/rhs_pkg.sv
package rhs_pkg;
   localparam int MAX_BANKS = 64;

   function automatic int unsigned flat_bank(input int unsigned rank,
                                             input int unsigned bank,
                                             input int unsigned per_rank);
      return rank * per_rank + bank;
   endfunction
endpackage

// File: rtl/rhs_snapshot.sv
module rhs_snapshot #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= d;
   end
endmodule

// File: rtl/rhs_bank_est.sv
module rhs_bank_est #(
   parameter int DEPTH = 16,
   parameter int NBANK = 16,
   parameter int BPR   = 8,
   parameter int RK_W  = 1,
   parameter int BK_W  = 3,
   parameter int TS_W  = 32,
   localparam int BID_W = $clog2(NBANK)
) (
   input  logic [DEPTH-1:0]       q_valid,
   input  logic [DEPTH*RK_W-1:0]  q_rank,
   input  logic [DEPTH*BK_W-1:0]  q_bank,
   input  logic [NBANK-1:0]       bk_open,
   input  logic [NBANK*TS_W-1:0]  bk_pre_at,
   input  logic [NBANK*TS_W-1:0]  bk_act_at,
   input  logic [TS_W-1:0]        now,
   input  logic [TS_W-1:0]        t_rp,
   output logic [NBANK*TS_W-1:0]  est,
   output logic [NBANK-1:0]       waiting,
   output logic [DEPTH*BID_W-1:0] ent_bank
);
   logic [BID_W-1:0] bid [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_comb begin
         bid[e] = BID_W'(rhs_pkg::flat_bank(int'(q_rank[e*RK_W +: RK_W]),
                                            int'(q_bank[e*BK_W +: BK_W]), BPR));
         ent_bank[e*BID_W +: BID_W] = bid[e];
      end
   end

   always_comb begin
      waiting = '0;
      for (int e = 0; e < DEPTH; e++)
         if (q_valid[e]) waiting[bid[e]] = 1'b1;
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [TS_W-1:0] pre_b, start_b;
      always_comb begin
         pre_b   = bk_pre_at[b*TS_W +: TS_W];
         start_b = (pre_b > now) ? pre_b : now;
         est[b*TS_W +: TS_W] = bk_open[b] ? start_b + t_rp
                                          : bk_act_at[b*TS_W +: TS_W];
      end
   end
endmodule

// File: rtl/rhs_min_mask.sv
module rhs_min_mask #(
   parameter int NBANK = 16,
   parameter int TS_W  = 32
) (
   input  logic [NBANK*TS_W-1:0] est,
   input  logic [NBANK-1:0]      waiting,
   output logic [NBANK-1:0]      mask
);
   logic [TS_W-1:0] mn;
   logic            found;

   always_comb begin
      mn    = '0;
      found = 1'b0;
      for (int b = 0; b < NBANK; b++) begin
         if (waiting[b] && (!found || est[b*TS_W +: TS_W] < mn)) begin
            mn    = est[b*TS_W +: TS_W];
            found = 1'b1;
         end
      end
      for (int b = 0; b < NBANK; b++)
         mask[b] = waiting[b] && (est[b*TS_W +: TS_W] == mn);
   end
endmodule

// File: rtl/rhs_pick.sv
module rhs_pick #(
   parameter int DEPTH = 16,
   parameter int NBANK = 16,
   parameter int ROW_W = 14,
   parameter int TS_W  = 32,
   localparam int BID_W = $clog2(NBANK),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0]       q_valid,
   input  logic [DEPTH*ROW_W-1:0] q_row,
   input  logic [DEPTH*BID_W-1:0] ent_bank,
   input  logic [NBANK-1:0]       bk_open,
   input  logic [NBANK*ROW_W-1:0] bk_row,
   input  logic [NBANK*TS_W-1:0]  est,
   input  logic [TS_W-1:0]        now,
   input  logic [NBANK-1:0]       mask,
   output logic                   valid,
   output logic                   hit,
   output logic [IDX_W-1:0]       idx
);
   logic [DEPTH-1:0] is_hit, is_ready;
   logic [IDX_W-1:0] hit_idx, rdy_idx;
   logic             rdy_found;

   for (genvar e = 0; e < DEPTH; e++) begin : g_cand
      logic [BID_W-1:0] b;
      always_comb begin
         b           = ent_bank[e*BID_W +: BID_W];
         is_hit[e]   = q_valid[e] && bk_open[b] &&
                       (bk_row[b*ROW_W +: ROW_W] == q_row[e*ROW_W +: ROW_W]);
         is_ready[e] = q_valid[e] &&
                       ((est[b*TS_W +: TS_W] <= now) || mask[b]);
      end
   end

   always_comb begin
      hit       = 1'b0;
      hit_idx   = '0;
      rdy_found = 1'b0;
      rdy_idx   = '0;
      for (int e = 0; e < DEPTH; e++) begin
         if (!hit && is_hit[e]) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(e);
         end
         if (!rdy_found && is_ready[e]) begin
            rdy_found = 1'b1;
            rdy_idx   = IDX_W'(e);
         end
      end
      valid = hit || rdy_found;
      idx   = hit ? hit_idx : rdy_idx;
   end
endmodule

// File: rtl/rowhit_selector.sv
module rowhit_selector #(
   parameter int DEPTH          = 16,
   parameter int RANKS          = 2,
   parameter int BANKS_PER_RANK = 8,
   parameter int ROW_W          = 14,
   parameter int TS_W           = 32,
   localparam int NBANK = RANKS * BANKS_PER_RANK,
   localparam int RK_W  = (RANKS > 1) ? $clog2(RANKS) : 1,
   localparam int BK_W  = (BANKS_PER_RANK > 1) ? $clog2(BANKS_PER_RANK) : 1,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [TS_W-1:0]        now_i,
   input  logic [TS_W-1:0]        t_rp_i,
   input  logic [DEPTH-1:0]       q_valid_i,
   input  logic [DEPTH*RK_W-1:0]  q_rank_i,
   input  logic [DEPTH*BK_W-1:0]  q_bank_i,
   input  logic [DEPTH*ROW_W-1:0] q_row_i,
   input  logic [NBANK-1:0]       bk_open_i,
   input  logic [NBANK*ROW_W-1:0] bk_row_i,
   input  logic [NBANK*TS_W-1:0]  bk_pre_at_i,
   input  logic [NBANK*TS_W-1:0]  bk_act_at_i,
   output logic                   pick_valid_o,
   output logic [IDX_W-1:0]       pick_idx_o,
   output logic [NBANK-1:0]       early_mask_o
);
   localparam int BID_W = $clog2(NBANK);
   localparam int SNAP_W = 2*TS_W + DEPTH*(1 + RK_W + BK_W + ROW_W)
                         + NBANK*(1 + ROW_W + 2*TS_W);

   if (NBANK > rhs_pkg::MAX_BANKS) begin : g_chk_banks
      $error("rowhit_selector: more than 64 banks");
   end
   if (NBANK < 2 || DEPTH < 2) begin : g_chk_size
      $error("rowhit_selector: need at least two banks and two entries");
   end
   if ((1 << BK_W) != BANKS_PER_RANK) begin : g_chk_pow2
      $error("rowhit_selector: banks per rank must be a power of two");
   end

   logic [TS_W-1:0]        now_s, t_rp_s;
   logic [DEPTH-1:0]       qv_s;
   logic [DEPTH*RK_W-1:0]  qrk_s;
   logic [DEPTH*BK_W-1:0]  qbk_s;
   logic [DEPTH*ROW_W-1:0] qrow_s;
   logic [NBANK-1:0]       bo_s;
   logic [NBANK*ROW_W-1:0] brow_s;
   logic [NBANK*TS_W-1:0]  bpre_s, bact_s;
   logic [SNAP_W-1:0]      snap_q;

   rhs_snapshot #(.W(SNAP_W)) u_snap (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({now_i, t_rp_i, q_valid_i, q_rank_i, q_bank_i, q_row_i,
               bk_open_i, bk_row_i, bk_pre_at_i, bk_act_at_i}),
      .q     (snap_q)
   );

   assign {now_s, t_rp_s, qv_s, qrk_s, qbk_s, qrow_s,
           bo_s, brow_s, bpre_s, bact_s} = snap_q;

   logic [NBANK*TS_W-1:0]  est;
   logic [NBANK-1:0]       waiting, mask;
   logic [DEPTH*BID_W-1:0] ent_bank;
   logic                   hit;

   rhs_bank_est #(
      .DEPTH(DEPTH), .NBANK(NBANK), .BPR(BANKS_PER_RANK),
      .RK_W(RK_W), .BK_W(BK_W), .TS_W(TS_W)
   ) u_est (
      .q_valid   (qv_s),
      .q_rank    (qrk_s),
      .q_bank    (qbk_s),
      .bk_open   (bo_s),
      .bk_pre_at (bpre_s),
      .bk_act_at (bact_s),
      .now       (now_s),
      .t_rp      (t_rp_s),
      .est       (est),
      .waiting   (waiting),
      .ent_bank  (ent_bank)
   );

   rhs_min_mask #(.NBANK(NBANK), .TS_W(TS_W)) u_min (
      .est     (est),
      .waiting (waiting),
      .mask    (mask)
   );

   rhs_pick #(
      .DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .TS_W(TS_W)
   ) u_pick (
      .q_valid  (qv_s),
      .q_row    (qrow_s),
      .ent_bank (ent_bank),
      .bk_open  (bo_s),
      .bk_row   (brow_s),
      .est      (est),
      .now      (now_s),
      .mask     (mask),
      .valid    (pick_valid_o),
      .hit      (hit),
      .idx      (pick_idx_o)
   );

   assign early_mask_o = hit ? '0 : mask;
endmodule

// File: rtl/rowhit_selector_chk.sv
module rowhit_selector_chk #(
   parameter int DEPTH = 16,
   parameter int NBANK = 16,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DEPTH-1:0] q_valid_i,
   input logic             pick_valid_o,
   input logic [IDX_W-1:0] pick_idx_o,
   input logic [NBANK-1:0] early_mask_o
);
   logic [DEPTH-1:0] qv_d;
   always_ff @(posedge clk) begin
      if (!rst_n) qv_d <= '0;
      else        qv_d <= q_valid_i;
   end

   // R1 R2: a pick exists exactly when the captured queue held work
   a_r1_valid_follows_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid_o == (|qv_d));

   // R10: the picked entry was valid in the captured queue
   a_r10_pick_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid_o |-> qv_d[pick_idx_o]);

   // R2: an empty queue leaves the mask clear
   a_r2_empty_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_valid_o |-> (early_mask_o == '0));

   // R7: a non-empty mask always comes with a pick
   a_r7_mask_implies_pick: assert property (@(posedge clk) disable iff (!rst_n)
      (early_mask_o != '0) |-> pick_valid_o);
endmodule

bind rowhit_selector rowhit_selector_chk #(.DEPTH(DEPTH), .NBANK(NBANK)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .q_valid_i    (q_valid_i),
   .pick_valid_o (pick_valid_o),
   .pick_idx_o   (pick_idx_o),
   .early_mask_o (early_mask_o)
);

// File: tb/rowhit_selector_test.sv
module rowhit_selector_test;
   localparam int DEPTH = 16, NB = 16, BPR = 8, ROW_W = 14, TS_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [TS_W-1:0] now_v, trp_v;
   logic            e_v   [DEPTH];
   int              e_rk  [DEPTH];
   int              e_bk  [DEPTH];
   int              e_row [DEPTH];
   logic            b_open[NB];
   int              b_row [NB];
   int              b_pre [NB];
   int              b_act [NB];

   logic [DEPTH-1:0]       q_valid;
   logic [DEPTH-1:0]       q_rank;
   logic [DEPTH*3-1:0]     q_bank;
   logic [DEPTH*ROW_W-1:0] q_row;
   logic [NB-1:0]          bk_open;
   logic [NB*ROW_W-1:0]    bk_row;
   logic [NB*TS_W-1:0]     bk_pre, bk_act;

   always_comb begin
      for (int e = 0; e < DEPTH; e++) begin
         q_valid[e]              = e_v[e];
         q_rank[e]               = e_rk[e][0];
         q_bank[e*3 +: 3]        = e_bk[e][2:0];
         q_row[e*ROW_W +: ROW_W] = e_row[e][ROW_W-1:0];
      end
      for (int b = 0; b < NB; b++) begin
         bk_open[b]               = b_open[b];
         bk_row[b*ROW_W +: ROW_W] = b_row[b][ROW_W-1:0];
         bk_pre[b*TS_W +: TS_W]   = b_pre[b];
         bk_act[b*TS_W +: TS_W]   = b_act[b];
      end
   end

   logic          pick_valid;
   logic [3:0]    pick_idx;
   logic [NB-1:0] early_mask;

   rowhit_selector uut (
      .clk (clk), .rst_n (rst_n), .now_i (now_v), .t_rp_i (trp_v),
      .q_valid_i (q_valid), .q_rank_i (q_rank), .q_bank_i (q_bank),
      .q_row_i (q_row), .bk_open_i (bk_open), .bk_row_i (bk_row),
      .bk_pre_at_i (bk_pre), .bk_act_at_i (bk_act),
      .pick_valid_o (pick_valid), .pick_idx_o (pick_idx),
      .early_mask_o (early_mask)
   );

   int n_checks = 0, n_fail = 0;

   task automatic check(input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_all();
      now_v = '0; trp_v = '0;
      for (int e = 0; e < DEPTH; e++) begin
         e_v[e] = 1'b0; e_rk[e] = 0; e_bk[e] = 0; e_row[e] = 0;
      end
      for (int b = 0; b < NB; b++) begin
         b_open[b] = 1'b0; b_row[b] = 0; b_pre[b] = 0; b_act[b] = 0;
      end
   endtask

   task automatic put(input int e, input int rk, input int bk, input int row);
      e_v[e] = 1'b1; e_rk[e] = rk; e_bk[e] = bk; e_row[e] = row;
   endtask

   // arithmetic model from the requirements
   task automatic model(output logic ev, output int eidx, output logic [NB-1:0] emask,
                        output logic ehit);
      longint est [NB];
      logic   wt  [NB];
      longint mn;
      logic   found;
      for (int b = 0; b < NB; b++) begin
         wt[b]  = 1'b0;
         est[b] = b_open[b] ? (((longint'(b_pre[b]) > longint'(now_v)) ?
                                longint'(b_pre[b]) : longint'(now_v)) + longint'(trp_v))
                            : longint'(b_act[b]);
      end
      for (int e = 0; e < DEPTH; e++)
         if (e_v[e]) wt[e_rk[e]*BPR + e_bk[e]] = 1'b1;
      found = 1'b0; mn = 0;
      for (int b = 0; b < NB; b++)
         if (wt[b] && (!found || est[b] < mn)) begin mn = est[b]; found = 1'b1; end
      emask = '0;
      for (int b = 0; b < NB; b++) emask[b] = wt[b] && est[b] == mn;
      ehit = 1'b0; ev = 1'b0; eidx = 0;
      for (int e = 0; e < DEPTH; e++) begin
         int fb;
         fb = e_rk[e]*BPR + e_bk[e];
         if (!ehit && e_v[e] && b_open[fb] && b_row[fb] == e_row[e]) begin
            ehit = 1'b1; eidx = e;
         end
      end
      if (ehit) begin
         ev = 1'b1; emask = '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            int fb;
            fb = e_rk[e]*BPR + e_bk[e];
            if (!ev && e_v[e] && (est[fb] <= longint'(now_v) || emask[fb])) begin
               ev = 1'b1; eidx = e;
            end
         end
      end
   endtask

   initial begin
      #(8 * 200000);
      n_checks++; n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      clear_all();
      repeat (3) @(negedge clk);
      check("R1", "valid in reset", pick_valid, 0);
      check("R1", "mask in reset", early_mask, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "valid after reset", pick_valid, 0);

      // R2: empty queue with busy banks
      b_open[3] = 1'b1; b_act[5] = 2;
      @(negedge clk);
      check("R2", "empty valid", pick_valid, 0);
      check("R2", "empty mask", early_mask, 0);

      // R3, R10: oldest hit, invalid matching entry ignored
      clear_all();
      now_v = 10; trp_v = 3;
      b_open[0] = 1'b1; b_row[0] = 5;
      b_open[9] = 1'b1; b_row[9] = 2;
      put(0, 0, 0, 7);
      e_rk[1] = 1; e_bk[1] = 1; e_row[1] = 2;
      put(2, 1, 1, 2);
      put(3, 0, 0, 5);
      #3;
      check("R1", "output held before edge", pick_valid, 0);
      @(negedge clk);
      check("R3", "hit valid", pick_valid, 1);
      check("R10", "hit idx skips invalid", pick_idx, 2);
      check("R3", "hit mask", early_mask, 0);

      // R4, R6: closed bank estimates, idle bank excluded
      @(negedge clk); clear_all();
      trp_v = 5;
      b_act[3] = 7; b_act[5] = 4; b_act[6] = 1;
      put(0, 0, 3, 1); put(1, 0, 5, 1);
      @(negedge clk);
      check("R4", "closed mask", early_mask, 16'h0020);
      check("R6", "closed idx", pick_idx, 1);

      // R5: open bank estimate
      @(negedge clk); clear_all();
      now_v = 10; trp_v = 3;
      b_open[2] = 1'b1; b_row[2] = 1; b_pre[2] = 12;
      b_open[4] = 1'b1; b_row[4] = 1; b_pre[4] = 6;
      b_act[7] = 14;
      put(0, 0, 2, 9); put(1, 0, 7, 9); put(2, 0, 4, 9);
      @(negedge clk);
      check("R5", "open mask", early_mask, 16'h0010);
      check("R5", "open idx", pick_idx, 2);

      // R7, R8: tie keeps both bits
      @(negedge clk); clear_all();
      trp_v = 2;
      b_act[1] = 8; b_act[10] = 8; b_act[0] = 9;
      put(0, 0, 0, 1); put(1, 1, 2, 1); put(2, 0, 1, 1);
      @(negedge clk);
      check("R7", "tie mask", early_mask, 16'h0402);
      check("R7", "tie idx", pick_idx, 1);

      // R8: rank 1 bank 3 maps to bit 11
      @(negedge clk); clear_all();
      b_act[11] = 50;
      put(0, 1, 3, 4);
      @(negedge clk);
      check("R8", "flat bit", early_mask, 16'h0800);
      check("R8", "flat idx", pick_idx, 0);

      // R9: older entry on ready but non-minimum bank wins
      @(negedge clk); clear_all();
      now_v = 10; trp_v = 2;
      b_act[0] = 9; b_act[1] = 3;
      put(0, 0, 0, 1); put(1, 0, 1, 1);
      @(negedge clk);
      check("R9", "ready mask", early_mask, 16'h0002);
      check("R9", "ready idx", pick_idx, 0);

      // R3: hit in last slot
      @(negedge clk); clear_all();
      b_open[0] = 1'b1; b_row[0] = 3;
      put(15, 0, 0, 3);
      @(negedge clk);
      check("R3", "last slot idx", pick_idx, 15);
      check("R3", "last slot valid", pick_valid, 1);

      // random sweep against the model
      for (int it = 0; it < 400; it++) begin
         logic          ev, eh;
         int            ei;
         logic [NB-1:0] em;
         @(negedge clk); clear_all();
         now_v = $urandom_range(0, 20);
         trp_v = $urandom_range(1, 4);
         for (int b = 0; b < NB; b++) begin
            b_open[b] = 1'($urandom_range(0, 1));
            b_row[b]  = $urandom_range(0, 3);
            b_pre[b]  = $urandom_range(0, 20);
            b_act[b]  = $urandom_range(0, 20);
         end
         for (int e = 0; e < DEPTH; e++) begin
            e_v[e]   = ($urandom_range(0, 3) == 0);
            e_rk[e]  = $urandom_range(0, 1);
            e_bk[e]  = $urandom_range(0, 7);
            e_row[e] = $urandom_range(0, 3);
         end
         model(ev, ei, em, eh);
         @(negedge clk);
         check(ev ? "R9" : "R2", "rand valid", pick_valid, ev);
         if (ev) check(eh ? "R3" : "R9", "rand idx", pick_idx, ei);
         check("R7", "rand mask", early_mask, em);
      end

      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule